// File: doc/BRIEF.md
# Time-Triggered Communication Cycle Sequencer

This block paces a time-triggered network node through its repeating communication cycle. One clock cycle is one macrotick. Each cycle is divided into up to four phases that always appear in the same order: a static segment made of equal-length numbered slots, an optional dynamic segment, an optional symbol window, and a network idle phase that takes whatever macroticks remain. The rest of the node uses the outputs to know which phase is active, which static slot (and so which frame ID) is being served, and when a new cycle begins. A 6-bit cycle number is kept for use in outgoing frame headers.

The block sits in a configuration state while `run_req` is low. When `run_req` goes high, the configuration inputs are checked. A valid set is captured, and the first cycle starts at the next clock edge. An invalid set is refused, and the block stays in the configuration state. After that capture, changes on the configuration inputs are ignored until the block returns to the configuration state. During network idle time the block raises a clock-correction window. The window covers every idle macrotick except the last macrotick of the cycle.

Top module: `tt_cycle_seq`

## Requirements
- R1: While reset is applied, and in the configuration state, `running`, `cycle_start` and `corr_win` are 0, `slot_num`, `cycle_cnt` and `mt_cnt` are 0, and `seg` is 3.
- R2: With a valid configuration, a high `run_req` in the configuration state starts the first cycle one clock later: `running`=1, `mt_cnt`=0, `cycle_start`=1, `cycle_cnt`=0, `slot_num`=1.
- R3: A configuration is refused, and `running` stays 0, when either of these holds: the slot count or the slot length is zero, or the sum of the static length (slots times slot length), the enabled dynamic length and the enabled symbol length is greater than the cycle length.
- R4: `seg` encodes static=0, dynamic=1, symbol=2, idle=3. At macrotick offset m of a cycle, `seg` is static for m below S (the static length), dynamic for m below S+D, symbol for m below S+D+Y, and idle otherwise.
- R5: A disabled dynamic segment or symbol window has length 0, whatever its length input holds.
- R6: Network idle time fills the rest of the cycle. When the enabled segments fill the cycle exactly, `seg` never shows idle.
- R7: Each cycle lasts exactly `cfg_cycle_len` clocks. `cycle_start` is high only at offset 0 of every cycle.
- R8: `cycle_cnt` goes up by one at each new cycle start and wraps from 63 to 0.
- R9: `slot_num` is 1 at the start of each cycle and equals floor(m / slot length)+1 inside the static segment. Outside the static segment it holds the slot count.
- R10: `corr_win` is high exactly on idle macroticks other than the final macrotick of the cycle.
- R11: Changes on the configuration inputs while running have no effect on the sequence.
- R12: Dropping `run_req` returns the block to the configuration state at the next clock, with the outputs at their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Macrotick clock |
| rst_n | input | 1 | Active-low reset |
| run_req | input | 1 | High requests running, low holds configuration state |
| cfg_cycle_len | input | MT_W | Cycle length in macroticks |
| cfg_slot_len | input | MT_W | Static slot length in macroticks |
| cfg_num_slots | input | SLOT_W | Number of static slots |
| cfg_dyn_en | input | 1 | Dynamic segment enable |
| cfg_dyn_len | input | MT_W | Dynamic segment length |
| cfg_sym_en | input | 1 | Symbol window enable |
| cfg_sym_len | input | MT_W | Symbol window length |
| running | output | 1 | Cycle sequencing active |
| seg | output | 2 | Current phase code |
| slot_num | output | SLOT_W | Current static slot number |
| cycle_start | output | 1 | High on the first macrotick of a cycle |
| cycle_cnt | output | CYC_W | Cycle number |
| corr_win | output | 1 | Clock-correction window |
| mt_cnt | output | MT_W | Macrotick offset within the cycle |

## Verification
On every cycle, the assertions check the following: the phase only moves forward within a cycle, the slot number steps only in the static segment and restarts at 1, the cycle number steps once per cycle start, a cycle wrap is followed by a start, and the correction window appears only in idle time. The bench scenarios are needed to show the exact segment boundaries for each enable combination, the refusal of oversized or degenerate configurations, the 63-to-0 wrap, and that inputs changed mid-run are ignored.

// File: rtl/tt_seq_pkg.sv
package tt_seq_pkg;
  typedef enum logic [1:0] {
    SEG_STATIC = 2'd0,
    SEG_DYN    = 2'd1,
    SEG_SYM    = 2'd2,
    SEG_IDLE   = 2'd3
  } seg_e;
endpackage

// File: rtl/tt_cfg_check.sv
module tt_cfg_check #(
  parameter int MT_W   = 16,
  parameter int SLOT_W = 10
) (
  input  logic [MT_W-1:0]   cycle_len,
  input  logic [MT_W-1:0]   slot_len,
  input  logic [SLOT_W-1:0] num_slots,
  input  logic              dyn_en,
  input  logic [MT_W-1:0]   dyn_len,
  input  logic              sym_en,
  input  logic [MT_W-1:0]   sym_len,
  output logic              cfg_ok,
  output logic [MT_W-1:0]   static_end,
  output logic [MT_W-1:0]   dyn_end,
  output logic [MT_W-1:0]   sym_end
);
  localparam int SUM_W = MT_W + SLOT_W + 2;

  // Length a segment occupies: zero when disabled (R5)
  function automatic logic [SUM_W-1:0] span(input logic en, input logic [MT_W-1:0] len);
    return en ? SUM_W'(len) : '0;
  endfunction

  logic [SUM_W-1:0] st_w, dy_w, sy_w;

  always_comb begin
    st_w = SUM_W'(num_slots) * SUM_W'(slot_len);
    dy_w = st_w + span(dyn_en, dyn_len);
    sy_w = dy_w + span(sym_en, sym_len);
    // R3: degenerate static segment or overfull cycle is refused
    cfg_ok = (num_slots != '0) && (slot_len != '0) && (sy_w <= SUM_W'(cycle_len));
    static_end = MT_W'(st_w);
    dyn_end    = MT_W'(dy_w);
    sym_end    = MT_W'(sy_w);
  end
endmodule

// File: rtl/tt_mt_timer.sv
module tt_mt_timer #(
  parameter int MT_W  = 16,
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             keep,
  input  logic [MT_W-1:0]  cyc_len,
  output logic [MT_W-1:0]  mt_cnt,
  output logic             cyc_wrap,
  output logic [CYC_W-1:0] cycle_cnt
);
  assign cyc_wrap = keep && (mt_cnt == cyc_len - MT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mt_cnt    <= '0;
      cycle_cnt <= '0;
    end else if (launch || !keep) begin
      mt_cnt    <= '0;
      cycle_cnt <= '0;
    end else if (cyc_wrap) begin
      mt_cnt    <= '0;
      cycle_cnt <= cycle_cnt + CYC_W'(1);
    end else begin
      mt_cnt    <= mt_cnt + MT_W'(1);
    end
  end
endmodule

// File: rtl/tt_slot_counter.sv
module tt_slot_counter #(
  parameter int MT_W   = 16,
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              keep,
  input  logic              cyc_wrap,
  input  logic [MT_W-1:0]   mt_cnt,
  input  logic [MT_W-1:0]   static_end,
  input  logic [MT_W-1:0]   slot_len,
  output logic [SLOT_W-1:0] slot_num,
  output logic              slot_adv
);
  logic [MT_W-1:0] slot_mt;
  logic            in_static_next;

  // True when the following macrotick is still in the static segment
  function automatic logic next_in_static(input logic [MT_W-1:0] m, input logic [MT_W-1:0] lim);
    return ({1'b0, m} + (MT_W+1)'(1)) < {1'b0, lim};
  endfunction

  assign in_static_next = next_in_static(mt_cnt, static_end);
  assign slot_adv = keep && !cyc_wrap && in_static_next && (slot_mt == slot_len - MT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_num <= '0;
      slot_mt  <= '0;
    end else if (launch || (keep && cyc_wrap)) begin
      slot_num <= SLOT_W'(1);
      slot_mt  <= '0;
    end else if (!keep) begin
      slot_num <= '0;
      slot_mt  <= '0;
    end else if (in_static_next) begin
      if (slot_adv) begin
        slot_num <= slot_num + SLOT_W'(1);
        slot_mt  <= '0;
      end else begin
        slot_mt  <= slot_mt + MT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tt_phase_decode.sv
module tt_phase_decode
  import tt_seq_pkg::*;
#(
  parameter int MT_W = 16
) (
  input  logic            running,
  input  logic [MT_W-1:0] mt_cnt,
  input  logic [MT_W-1:0] cyc_len,
  input  logic [MT_W-1:0] static_end,
  input  logic [MT_W-1:0] dyn_end,
  input  logic [MT_W-1:0] sym_end,
  output seg_e            seg_now,
  output logic            corr_win,
  output logic            cycle_start
);
  function automatic seg_e seg_of(input logic [MT_W-1:0] m, input logic [MT_W-1:0] e_st,
                                  input logic [MT_W-1:0] e_dy, input logic [MT_W-1:0] e_sy);
    if (m < e_st) return SEG_STATIC;
    if (m < e_dy) return SEG_DYN;
    if (m < e_sy) return SEG_SYM;
    return SEG_IDLE;
  endfunction

  always_comb begin
    seg_now     = running ? seg_of(mt_cnt, static_end, dyn_end, sym_end) : SEG_IDLE;
    corr_win    = running && (seg_now == SEG_IDLE) && (mt_cnt != cyc_len - MT_W'(1));
    cycle_start = running && (mt_cnt == '0);
  end
endmodule

// File: rtl/tt_cycle_seq.sv
module tt_cycle_seq
  import tt_seq_pkg::*;
#(
  parameter int MT_W   = 16,
  parameter int SLOT_W = 10,
  parameter int CYC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  input  logic [MT_W-1:0]   cfg_cycle_len,
  input  logic [MT_W-1:0]   cfg_slot_len,
  input  logic [SLOT_W-1:0] cfg_num_slots,
  input  logic              cfg_dyn_en,
  input  logic [MT_W-1:0]   cfg_dyn_len,
  input  logic              cfg_sym_en,
  input  logic [MT_W-1:0]   cfg_sym_len,
  output logic              running,
  output logic [1:0]        seg,
  output logic [SLOT_W-1:0] slot_num,
  output logic              cycle_start,
  output logic [CYC_W-1:0]  cycle_cnt,
  output logic              corr_win,
  output logic [MT_W-1:0]   mt_cnt
);
  logic            cfg_ok, launch, keep, cyc_wrap, slot_adv;
  logic [MT_W-1:0] st_end_d, dy_end_d, sy_end_d;
  logic [MT_W-1:0] cyc_len_q, slot_len_q, st_end_q, dy_end_q, sy_end_q;
  seg_e            seg_now;

  tt_cfg_check #(.MT_W(MT_W), .SLOT_W(SLOT_W)) u_cfg (
    .cycle_len(cfg_cycle_len), .slot_len(cfg_slot_len), .num_slots(cfg_num_slots),
    .dyn_en(cfg_dyn_en), .dyn_len(cfg_dyn_len), .sym_en(cfg_sym_en), .sym_len(cfg_sym_len),
    .cfg_ok(cfg_ok), .static_end(st_end_d), .dyn_end(dy_end_d), .sym_end(sy_end_d)
  );

  assign launch = !running && run_req && cfg_ok;
  assign keep   = running && run_req;

  // Configuration is captured only when leaving the configuration state (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cyc_len_q  <= '0;
      slot_len_q <= '0;
      st_end_q   <= '0;
      dy_end_q   <= '0;
      sy_end_q   <= '0;
    end else begin
      running <= keep || launch;
      if (launch) begin
        cyc_len_q  <= cfg_cycle_len;
        slot_len_q <= cfg_slot_len;
        st_end_q   <= st_end_d;
        dy_end_q   <= dy_end_d;
        sy_end_q   <= sy_end_d;
      end
    end
  end

  tt_mt_timer #(.MT_W(MT_W), .CYC_W(CYC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .keep(keep), .cyc_len(cyc_len_q),
    .mt_cnt(mt_cnt), .cyc_wrap(cyc_wrap), .cycle_cnt(cycle_cnt)
  );

  tt_slot_counter #(.MT_W(MT_W), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .launch(launch), .keep(keep), .cyc_wrap(cyc_wrap),
    .mt_cnt(mt_cnt), .static_end(st_end_q), .slot_len(slot_len_q),
    .slot_num(slot_num), .slot_adv(slot_adv)
  );

  tt_phase_decode #(.MT_W(MT_W)) u_phase (
    .running(running), .mt_cnt(mt_cnt), .cyc_len(cyc_len_q),
    .static_end(st_end_q), .dyn_end(dy_end_q), .sym_end(sy_end_q),
    .seg_now(seg_now), .corr_win(corr_win), .cycle_start(cycle_start)
  );

  assign seg = seg_now;
endmodule

// File: rtl/tt_cycle_seq_chk.sv
module tt_cycle_seq_chk #(
  parameter int SLOT_W = 10,
  parameter int CYC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              running,
  input logic [1:0]        seg,
  input logic [SLOT_W-1:0] slot_num,
  input logic              cycle_start,
  input logic [CYC_W-1:0]  cycle_cnt,
  input logic              corr_win,
  input logic              slot_adv,
  input logic              cyc_wrap
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (slot_num == '0 && cycle_cnt == '0 && !corr_win && !cycle_start));

  p_launch_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (cycle_start && slot_num == SLOT_W'(1) && cycle_cnt == '0));

  p_seg_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !cycle_start) |-> (seg >= $past(seg)));

  p_wrap_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> (cycle_start || !running));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && cycle_start) |-> (cycle_cnt == CYC_W'($past(cycle_cnt) + 1)));

  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !cycle_start) |-> $stable(cycle_cnt));

  p_slot_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> (slot_num == SLOT_W'(1)));

  p_slot_adv_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_adv |-> (seg == 2'd0));

  p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !cycle_start && $past(seg) != 2'd0) |-> $stable(slot_num));

  p_corr_in_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    corr_win |-> (seg == 2'd3 && running));
endmodule

bind tt_cycle_seq tt_cycle_seq_chk #(.SLOT_W(SLOT_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .seg(seg), .slot_num(slot_num),
  .cycle_start(cycle_start), .cycle_cnt(cycle_cnt), .corr_win(corr_win),
  .slot_adv(slot_adv), .cyc_wrap(cyc_wrap)
);

// File: tb/tt_cycle_seq_test.sv
module tt_cycle_seq_test;
  localparam int MT_W = 16, SLOT_W = 10, CYC_W = 6;

  typedef struct packed {
    int cyc; int sl; int ns; bit de; int dl; bit se; int syl; bit ok;
  } vec_t;

  // cycle, slot len, slots, dyn en, dyn len, sym en, sym len, accepted
  localparam vec_t VECS [9] = '{
    '{40, 5, 3, 1'b1, 10, 1'b1, 4, 1'b1},   // all four phases
    '{30, 4, 2, 1'b0, 10, 1'b1, 3, 1'b1},   // dynamic off (R5)
    '{20, 3, 4, 1'b1, 5, 1'b0, 9, 1'b1},    // symbol off (R5)
    '{16, 4, 2, 1'b1, 5, 1'b1, 3, 1'b1},    // exact fill, no idle (R6)
    '{20, 5, 3, 1'b1, 6, 1'b0, 0, 1'b0},    // overfull by one (R3)
    '{25, 0, 3, 1'b0, 0, 1'b0, 0, 1'b0},    // zero slot length (R3)
    '{10, 2, 5, 1'b0, 0, 1'b0, 0, 1'b1},    // static only fills cycle (R6)
    '{12, 4, 2, 1'b0, 7, 1'b1, 9, 1'b0},    // symbol overfills (R3)
    '{12, 4, 2, 1'b0, 50, 1'b0, 50, 1'b1}   // disabled lengths ignored (R5)
  };

  logic clk = 1'b0, rst_n = 1'b0, run_req = 1'b0;
  logic [MT_W-1:0] cfg_cycle_len = '0, cfg_slot_len = '0, cfg_dyn_len = '0, cfg_sym_len = '0;
  logic [SLOT_W-1:0] cfg_num_slots = '0;
  logic cfg_dyn_en = 1'b0, cfg_sym_en = 1'b0;
  logic running, cycle_start, corr_win;
  logic [1:0] seg;
  logic [SLOT_W-1:0] slot_num;
  logic [CYC_W-1:0] cycle_cnt;
  logic [MT_W-1:0] mt_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tt_cycle_seq #(.MT_W(MT_W), .SLOT_W(SLOT_W), .CYC_W(CYC_W)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int e_seg(vec_t v, int m);
    int s = v.sl * v.ns;
    int d = s + (v.de ? v.dl : 0);
    int y = d + (v.se ? v.syl : 0);
    if (m < s) return 0;
    if (m < d) return 1;
    if (m < y) return 2;
    return 3;
  endfunction

  task automatic apply(vec_t v);
    cfg_cycle_len = MT_W'(v.cyc);
    cfg_slot_len  = MT_W'(v.sl);
    cfg_num_slots = SLOT_W'(v.ns);
    cfg_dyn_en    = v.de;
    cfg_dyn_len   = MT_W'(v.dl);
    cfg_sym_en    = v.se;
    cfg_sym_len   = MT_W'(v.syl);
  endtask

  // Called at the negedge where offset 0 of cycle k is visible; returns at the next cycle's offset 0
  task automatic walk_cycle(vec_t v, int k, string tag);
    for (int m = 0; m < v.cyc; m++) begin
      int es = e_seg(v, m);
      chk({tag, " R4 R5 R6 seg"}, int'(seg), es);
      chk({tag, " R7 mt"}, int'(mt_cnt), m);
      chk({tag, " R7 cycle_start"}, int'(cycle_start), (m == 0) ? 1 : 0);
      chk({tag, " R8 cycle_cnt"}, int'(cycle_cnt), k % 64);
      chk({tag, " R9 slot"}, int'(slot_num), (m < v.sl * v.ns) ? (m / v.sl + 1) : v.ns);
      chk({tag, " R10 corr_win"}, int'(corr_win), (es == 3 && m != v.cyc - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic check_idle(string tag);
    chk({tag, " running"}, int'(running), 0);
    chk({tag, " slot"}, int'(slot_num), 0);
    chk({tag, " cycle_cnt"}, int'(cycle_cnt), 0);
    chk({tag, " corr_win"}, int'(corr_win), 0);
    chk({tag, " cycle_start"}, int'(cycle_start), 0);
    chk({tag, " seg"}, int'(seg), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // Table walk
    for (int i = 0; i < 9; i++) begin
      apply(VECS[i]);
      run_req = 1'b1;
      @(negedge clk);
      if (VECS[i].ok) begin
        chk("R2 running", int'(running), 1);
        chk("R2 slot", int'(slot_num), 1);
        walk_cycle(VECS[i], 0, "vec");
        walk_cycle(VECS[i], 1, "vec");
      end else begin
        for (int w = 0; w < 3; w++) begin
          chk("R3 refused", int'(running), 0);
          @(negedge clk);
        end
      end
      run_req = 1'b0;
      @(negedge clk);
      check_idle("R12 stop");
    end

    // R11: inputs changed mid-run are ignored
    apply(VECS[0]);
    run_req = 1'b1;
    @(negedge clk);
    apply(VECS[6]);
    walk_cycle(VECS[0], 0, "R11");
    walk_cycle(VECS[0], 1, "R11");
    run_req = 1'b0;
    @(negedge clk);
    check_idle("R12 stop");

    // R8: cycle counter wraps 63 -> 0
    apply('{3, 1, 1, 1'b0, 0, 1'b0, 0, 1'b1});
    run_req = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 66; k++) walk_cycle('{3, 1, 1, 1'b0, 0, 1'b0, 0, 1'b1}, k, "R8 wrap");
    chk("R8 after wrap", int'(cycle_cnt), 2);
    run_req = 1'b0;
    @(negedge clk);
    check_idle("R12 stop");

    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end
endmodule